// File: doc/BRIEF.md
# VLIW Fetch Packet Dispatcher

This block sits between instruction fetch and issue in a very-long-instruction-word core. It receives aligned fetch packets of eight 32-bit operations and splits each one into execute packets, giving the issue stage one execute packet per cycle. A chaining flag in bit 0 of every operation decides whether the following operation joins the same execute packet. One fetch packet may therefore hold anything from a single eight-wide execute packet to eight single-operation packets.

Operations are presented in their original slot positions along with a valid mask. Only the slots of the current execute packet are marked valid, and every other slot reads as zero. A single ready input from issue stalls the block. When the final execute packet of a fetch packet leaves, the block requests the next fetch packet in the same cycle, so a packet supplied at once follows with no gap. A redirect input loads a new fetch packet at any word index, including one in the middle of an execute packet. It discards whatever was in progress.

Top module: `vliw_pkt_dispatch`

## Requirements
- R1: During and right after reset, `ep_valid_o` is 0, `ep_mask_o` is 0 and `fetch_req_o` is 1.
- R2: With `fetch_req_o` high and `fp_valid_i` high at a clock edge, the packet on `fp_data_i` is loaded, and dispatch begins at word 0 in the next cycle.
- R3: The valid mask is contiguous. It starts at the current start word and covers each following word while the previous word's bit 0 is 1. It ends at the first word whose bit 0 is 0. Word i occupies `fp_data_i[32*i+31:32*i]`, and mask bit i stands for word i.
- R4: An execute packet never runs past word 7, even when word 7 has bit 0 set.
- R5: Each slot whose mask bit is set carries its operation word unchanged. Every other slot of `ep_ops_o` is zero.
- R6: While `issue_ready_i` is low and no redirect is present, the mask, the operations and `ep_valid_o` hold their values.
- R7: With `issue_ready_i` high and the current execute packet not ending at word 7, the next cycle's execute packet starts at the word after the current packet's last word.
- R8: In a cycle where the execute packet ending at word 7 is shown and `issue_ready_i` is high, `fetch_req_o` is 1. A packet supplied in that cycle is dispatched in the next cycle with no gap. Otherwise the block goes empty (`ep_valid_o` 0) and keeps `fetch_req_o` at 1 until a packet arrives.
- R9: A redirect (`redir_valid_i` high) loads `fp_data_i` with the start word set to `redir_idx_i` and discards the current packet. Words below that index are never marked valid. A redirect takes priority over a normal load.
- R10: `fp_valid_i` is ignored while `fetch_req_o` is low.
- R11: A fetch packet whose words 0 to 6 all have bit 0 set, entered at word 0, issues as one eight-wide execute packet with mask 0xFF.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| fp_valid_i | input | 1 | Fetch packet present on `fp_data_i` |
| fp_data_i | input | 256 | Fetch packet, word i in bits 32*i+31 down to 32*i |
| redir_valid_i | input | 1 | Branch redirect: load `fp_data_i` at `redir_idx_i` |
| redir_idx_i | input | 3 | Target word index for a redirect |
| issue_ready_i | input | 1 | Issue stage accepts the shown execute packet |
| ep_valid_o | output | 1 | An execute packet is being shown |
| ep_mask_o | output | 8 | Valid slots of the current execute packet |
| ep_ops_o | output | 256 | Operation words in their slots, with invalid slots zeroed |
| fetch_req_o | output | 1 | Request for the next fetch packet |

## Verification
Every output is derived combinationally from registered state. A load, a redirect or an advance therefore appears one clock edge after the inputs that cause it, and the bench drives inputs at the falling edge and checks the result at the following falling edge. `fetch_req_o` is an exception, because it depends on `issue_ready_i` within the same cycle. It is checked at the same falling edge as the execute packet it belongs to. For the stall case, the check is repeated on several consecutive falling edges. For the back-to-back case, the new packet's first execute packet is expected exactly one edge after the final execute packet of the old one.

// File: rtl/vpd_pkg.sv
package vpd_pkg;
    localparam int unsigned VPD_SLOTS = 8;
    localparam int unsigned VPD_OPW   = 32;
    localparam int unsigned VPD_PBIT  = 0;
endpackage

// File: rtl/vpd_boundary.sv
module vpd_boundary #(
    parameter  int SLOTS = 8,
    localparam int IDXW  = $clog2(SLOTS)
) (
    input  logic [SLOTS-1:0] chain_i,
    input  logic [IDXW-1:0]  start_i,
    output logic [SLOTS-1:0] mask_o,
    output logic [IDXW-1:0]  end_o,
    output logic             last_o
);
    always_comb begin
        logic run;
        logic prev;
        run  = 1'b0;
        prev = 1'b0;
        end_o = '0;
        for (int i = 0; i < SLOTS; i++) begin
            run       = (start_i == IDXW'(i)) | (run & prev);
            mask_o[i] = run;
            prev      = chain_i[i];
            if (run) end_o = IDXW'(i);
        end
        last_o = mask_o[SLOTS-1];
    end
endmodule

// File: rtl/vpd_slot_mux.sv
module vpd_slot_mux #(
    parameter int SLOTS = 8,
    parameter int OPW   = 32
) (
    input  logic [SLOTS*OPW-1:0] ops_i,
    input  logic [SLOTS-1:0]     mask_i,
    output logic [SLOTS*OPW-1:0] ops_o
);
    for (genvar g = 0; g < SLOTS; g++) begin : g_slot
        assign ops_o[g*OPW +: OPW] = mask_i[g] ? ops_i[g*OPW +: OPW] : '0;
    end
endmodule

// File: rtl/vliw_pkt_dispatch.sv
module vliw_pkt_dispatch
    import vpd_pkg::*;
#(
    parameter  int SLOTS = VPD_SLOTS,
    parameter  int OPW   = VPD_OPW,
    parameter  int PBIT  = VPD_PBIT,
    localparam int IDXW  = $clog2(SLOTS),
    localparam int PKTW  = SLOTS * OPW
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            fp_valid_i,
    input  logic [PKTW-1:0] fp_data_i,
    input  logic            redir_valid_i,
    input  logic [IDXW-1:0] redir_idx_i,
    input  logic            issue_ready_i,
    output logic            ep_valid_o,
    output logic [SLOTS-1:0] ep_mask_o,
    output logic [PKTW-1:0] ep_ops_o,
    output logic            fetch_req_o
);
    typedef struct packed {
        logic [PKTW-1:0] pkt;
        logic [IDXW-1:0] ptr;
        logic            full;
    } disp_st_t;

    disp_st_t st_d, st_q;

    logic [SLOTS-1:0] chain_w;
    logic [SLOTS-1:0] span_w;
    logic [IDXW-1:0]  end_w;
    logic             last_w;

    for (genvar g = 0; g < SLOTS; g++) begin : g_chain
        assign chain_w[g] = st_q.pkt[g*OPW + PBIT];
    end

    vpd_boundary #(.SLOTS(SLOTS)) bnd_i (
        .chain_i (chain_w),
        .start_i (st_q.ptr),
        .mask_o  (span_w),
        .end_o   (end_w),
        .last_o  (last_w)
    );

    assign ep_valid_o = st_q.full;
    assign ep_mask_o  = st_q.full ? span_w : '0;

    vpd_slot_mux #(.SLOTS(SLOTS), .OPW(OPW)) mux_i (
        .ops_i  (st_q.pkt),
        .mask_i (ep_mask_o),
        .ops_o  (ep_ops_o)
    );

    always_comb begin
        st_d        = st_q;
        fetch_req_o = !st_q.full | (issue_ready_i & last_w);
        if (redir_valid_i) begin
            st_d.pkt  = fp_data_i;
            st_d.ptr  = redir_idx_i;
            st_d.full = 1'b1;
        end else if (fetch_req_o && fp_valid_i) begin
            st_d.pkt  = fp_data_i;
            st_d.ptr  = '0;
            st_d.full = 1'b1;
        end else if (st_q.full && issue_ready_i) begin
            if (last_w) begin
                st_d.full = 1'b0;
            end else begin
                st_d.ptr = end_w + IDXW'(1);
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end
endmodule

// File: rtl/vpd_checker.sv
module vpd_checker #(
    parameter  int SLOTS = 8,
    parameter  int OPW   = 32,
    localparam int IDXW  = $clog2(SLOTS)
) (
    input logic                 clk,
    input logic                 rst_n,
    input logic                 fp_valid_i,
    input logic                 redir_valid_i,
    input logic [IDXW-1:0]      redir_idx_i,
    input logic                 issue_ready_i,
    input logic                 ep_valid_o,
    input logic [SLOTS-1:0]     ep_mask_o,
    input logic [SLOTS*OPW-1:0] ep_ops_o,
    input logic                 fetch_req_o
);
    assert_req_when_empty_R1: assert property (@(posedge clk) disable iff (!rst_n)
        !ep_valid_o |-> (fetch_req_o && ep_mask_o == '0));

    assert_mask_present_R3: assert property (@(posedge clk) disable iff (!rst_n)
        ep_valid_o |-> (ep_mask_o != '0));

    assert_mask_contig_R3: assert property (@(posedge clk) disable iff (!rst_n)
        ((((ep_mask_o | (ep_mask_o - SLOTS'(1))) + SLOTS'(1)) & ep_mask_o) == '0));

    assert_stall_hold_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (ep_valid_o && !issue_ready_i && !redir_valid_i) |=>
        (ep_valid_o && $stable(ep_mask_o) && $stable(ep_ops_o)));

    assert_drain_empty_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (ep_valid_o && issue_ready_i && ep_mask_o[SLOTS-1] && !fp_valid_i && !redir_valid_i) |=>
        !ep_valid_o);

    assert_last_requests_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (ep_valid_o && issue_ready_i && ep_mask_o[SLOTS-1]) |-> fetch_req_o);

    assert_redir_entry_R9: assert property (@(posedge clk) disable iff (!rst_n)
        redir_valid_i |=> (ep_valid_o && ep_mask_o[$past(redir_idx_i)]));

    assert_redir_skip_R9: assert property (@(posedge clk) disable iff (!rst_n)
        redir_valid_i |=>
        ((ep_mask_o & ((SLOTS'(1) << $past(redir_idx_i)) - SLOTS'(1))) == '0));
endmodule

bind vliw_pkt_dispatch vpd_checker #(.SLOTS(SLOTS), .OPW(OPW)) chk_i (
    .clk           (clk),
    .rst_n         (rst_n),
    .fp_valid_i    (fp_valid_i),
    .redir_valid_i (redir_valid_i),
    .redir_idx_i   (redir_idx_i),
    .issue_ready_i (issue_ready_i),
    .ep_valid_o    (ep_valid_o),
    .ep_mask_o     (ep_mask_o),
    .ep_ops_o      (ep_ops_o),
    .fetch_req_o   (fetch_req_o)
);

// File: tb/vliw_pkt_dispatch_tb.sv
module vliw_pkt_dispatch_tb_top;
    localparam int SLOTS = 8;
    localparam int OPW   = 32;
    localparam int PKTW  = SLOTS * OPW;

    typedef struct packed {
        logic        redir;
        logic [2:0]  start;
        logic [7:0]  pbits;
        logic [3:0]  nexp;
        logic [63:0] masks;
    } vec_t;

    localparam int NVEC = 7;
    localparam logic [79:0] VEC [NVEC] = '{
        {1'b0, 3'd0, 8'h00, 4'd8, 64'h8040_2010_0804_0201},
        {1'b0, 3'd0, 8'hFF, 4'd1, 64'h0000_0000_0000_00FF},
        {1'b0, 3'd0, 8'h7A, 4'd3, 64'h0000_0000_00F8_0601},
        {1'b1, 3'd2, 8'h7A, 4'd2, 64'h0000_0000_0000_F804},
        {1'b1, 3'd5, 8'h7A, 4'd1, 64'h0000_0000_0000_00E0},
        {1'b0, 3'd0, 8'h0F, 4'd4, 64'h0000_0000_8040_201F},
        {1'b1, 3'd7, 8'hFF, 4'd1, 64'h0000_0000_0000_0080}
    };

    logic             clk = 1'b0;
    logic             rst_n = 1'b0;
    logic             fp_valid_i = 1'b0;
    logic [PKTW-1:0]  fp_data_i = '0;
    logic             redir_valid_i = 1'b0;
    logic [2:0]       redir_idx_i = '0;
    logic             issue_ready_i = 1'b1;
    logic             ep_valid_o;
    logic [SLOTS-1:0] ep_mask_o;
    logic [PKTW-1:0]  ep_ops_o;
    logic             fetch_req_o;

    int n_cmp = 0;
    int n_bad = 0;

    always #4 clk = ~clk;

    vliw_pkt_dispatch dut_i (
        .clk           (clk),
        .rst_n         (rst_n),
        .fp_valid_i    (fp_valid_i),
        .fp_data_i     (fp_data_i),
        .redir_valid_i (redir_valid_i),
        .redir_idx_i   (redir_idx_i),
        .issue_ready_i (issue_ready_i),
        .ep_valid_o    (ep_valid_o),
        .ep_mask_o     (ep_mask_o),
        .ep_ops_o      (ep_ops_o),
        .fetch_req_o   (fetch_req_o)
    );

    function automatic logic [PKTW-1:0] mk_pkt(int tag, logic [7:0] pbits);
        logic [PKTW-1:0] p;
        for (int i = 0; i < SLOTS; i++) begin
            p[i*OPW +: OPW] = (32'(tag + 1) << 24) | (32'(i) << 8) | {31'd0, pbits[i]};
        end
        return p;
    endfunction

    function automatic logic [PKTW-1:0] gate(logic [PKTW-1:0] p, logic [7:0] m);
        logic [PKTW-1:0] r;
        for (int i = 0; i < SLOTS; i++) begin
            r[i*OPW +: OPW] = m[i] ? p[i*OPW +: OPW] : '0;
        end
        return r;
    endfunction

    task automatic chk(string req, logic [PKTW-1:0] got, logic [PKTW-1:0] exp);
        n_cmp++;
        if (got !== exp) begin
            n_bad++;
            $display("FAIL %s: got %0h expected %0h", req, got, exp);
        end
    endtask

    task automatic finish_run();
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    endtask

    task automatic drain();
        for (int k = 0; k < 20; k++) begin
            if (!ep_valid_o) break;
            @(negedge clk);
        end
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        n_cmp++;
        n_bad++;
        $display("FAIL watchdog: got timeout expected completion");
        finish_run();
    end

    initial begin
        logic [PKTW-1:0] pk;
        logic [PKTW-1:0] pk2;
        // Reset state
        repeat (3) @(negedge clk);
        chk("R1 valid", PKTW'(ep_valid_o), PKTW'(0));
        chk("R1 mask", PKTW'(ep_mask_o), PKTW'(0));
        chk("R1 req", PKTW'(fetch_req_o), PKTW'(1));
        rst_n = 1'b1;
        @(negedge clk);
        chk("R1 after release", PKTW'({ep_valid_o, fetch_req_o}), PKTW'(2'b01));

        // Vector table
        for (int v = 0; v < NVEC; v++) begin
            vec_t e;
            e  = VEC[v];
            pk = mk_pkt(v, e.pbits);
            fp_data_i = pk;
            if (e.redir) begin
                redir_valid_i = 1'b1;
                redir_idx_i   = e.start;
            end else begin
                fp_valid_i = 1'b1;
            end
            @(negedge clk);
            redir_valid_i = 1'b0;
            fp_valid_i    = 1'b0;
            for (int k = 0; k < int'(e.nexp); k++) begin
                logic [7:0] m;
                m = e.masks[k*8 +: 8];
                chk(e.redir ? "R9 valid" : "R2 valid", PKTW'(ep_valid_o), PKTW'(1));
                chk(v == 1 ? "R11 mask" : (k > 0 ? "R7 mask" : "R3 mask"), PKTW'(ep_mask_o), PKTW'(m));
                chk("R5 ops", ep_ops_o, gate(pk, m));
                chk(m[7] ? "R8 req last" : "R4 req mid", PKTW'(fetch_req_o), PKTW'(k == int'(e.nexp) - 1));
                @(negedge clk);
            end
            chk("R8 empty", PKTW'({ep_valid_o, fetch_req_o}), PKTW'(2'b01));
        end

        // Stall, ignored fetch data, then advance and redirect flush
        pk = mk_pkt(20, 8'h7A);
        issue_ready_i = 1'b0;
        fp_data_i  = pk;
        fp_valid_i = 1'b1;
        @(negedge clk);
        fp_valid_i = 1'b0;
        chk("R2 stall load", PKTW'(ep_mask_o), PKTW'(8'h01));
        fp_data_i  = mk_pkt(21, 8'h00);
        fp_valid_i = 1'b1;
        chk("R10 req low", PKTW'(fetch_req_o), PKTW'(0));
        @(negedge clk);
        fp_valid_i = 1'b0;
        chk("R10 ops kept", ep_ops_o, gate(pk, 8'h01));
        @(negedge clk);
        chk("R6 mask held", PKTW'(ep_mask_o), PKTW'(8'h01));
        chk("R6 ops held", ep_ops_o, gate(pk, 8'h01));
        issue_ready_i = 1'b1;
        @(negedge clk);
        chk("R7 advance", PKTW'(ep_mask_o), PKTW'(8'h06));
        pk2 = mk_pkt(22, 8'h00);
        fp_data_i     = pk2;
        redir_valid_i = 1'b1;
        redir_idx_i   = 3'd3;
        fp_valid_i    = 1'b1;
        @(negedge clk);
        redir_valid_i = 1'b0;
        fp_valid_i    = 1'b0;
        chk("R9 flush mask", PKTW'(ep_mask_o), PKTW'(8'h08));
        chk("R9 flush ops", ep_ops_o, gate(pk2, 8'h08));
        drain();

        // Back-to-back packets with no gap
        pk = mk_pkt(30, 8'hFF);
        fp_data_i  = pk;
        fp_valid_i = 1'b1;
        @(negedge clk);
        chk("R11 full width", PKTW'(ep_mask_o), PKTW'(8'hFF));
        chk("R8 req same cycle", PKTW'(fetch_req_o), PKTW'(1));
        pk2 = mk_pkt(31, 8'h00);
        fp_data_i = pk2;
        @(negedge clk);
        fp_valid_i = 1'b0;
        chk("R8 no gap", PKTW'({ep_valid_o, ep_mask_o}), PKTW'({1'b1, 8'h01}));
        chk("R8 no gap ops", ep_ops_o, gate(pk2, 8'h01));
        drain();

        // Empty state persists until a packet is supplied
        repeat (4) @(negedge clk);
        chk("R8 wait empty", PKTW'({ep_valid_o, fetch_req_o}), PKTW'(2'b01));

        finish_run();
    end
endmodule